// File: doc/BRIEF.md
# Asynchronous SRAM Bus-Width Bridge

The bridge connects a simple single-outstanding request bus inside a chip to an external asynchronous static RAM whose data path is fixed at 16 bits. Each request carries a byte address, a size (byte, halfword or word), a write flag and 32 bits of write data. The bridge turns each request into one or two memory accesses. Every access has a programmable address-setup phase, address-hold phase and data phase, and accesses are separated by a programmable bus-turnaround gap. A word request becomes two back-to-back halfword accesses. Byte writes are confined to one byte through two active-low lane enables. Reads always fetch the full halfword and pick out the wanted byte inside the bridge.

The controlling state machine has six states. `ST_IDLE` waits for a request. `ST_SETUP` drives the address with chip select low. `ST_HOLD` keeps the address stable before the strobe. `ST_DATA` asserts the read or write strobe. `ST_RESP` returns the response for one cycle. `ST_TURN` holds chip select high for the turnaround gap.

The transitions are as follows:
- IDLE→SETUP: a request is accepted and is allowed by the configuration.
- IDLE→RESP: a request is rejected.
- SETUP→HOLD: the setup count expires and the hold count is non-zero.
- SETUP→DATA: the setup count expires and the hold count is zero.
- HOLD→DATA: the hold count expires.
- DATA→TURN: the first half of a word is done and the turnaround count is non-zero.
- DATA→SETUP: the first half of a word is done and the turnaround count is zero.
- DATA→RESP: the last access is done.
- RESP→TURN: an access took place and the turnaround count is non-zero.
- RESP→IDLE: otherwise.
- TURN→SETUP: the second half of a word is still to come.
- TURN→IDLE: the response has already been given.

Top module: `sram_bridge`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `mem_lane_n` is 2'b11, `req_ready` is high and `rsp_valid` is low. Whenever chip select is high, the lane enables are 2'b11.
- R2: A halfword request (`req_size` 2'b01) makes one access at halfword address `req_addr[18:1]`. A read returns the memory halfword in `rsp_rdata[15:0]`, with the upper 16 bits zero.
- R3: A word request (`req_size` 2'b10) makes two accesses, first at `{req_addr[18:2],0}` and then at `{req_addr[18:2],1}`. A read returns `{second,first}`. A write stores `req_wdata[15:0]` in the first halfword and `req_wdata[31:16]` in the second. Only one response is given, after both accesses.
- R4: A byte write (`req_size` 2'b00) with `req_addr[0]`=0 drives `mem_lane_n`=2'b10, which enables `mem_dq[7:0]`. With `req_addr[0]`=1 it drives 2'b01, which enables `mem_dq[15:8]`. The other byte of the memory word is left unchanged.
- R5: Every read holds `mem_lane_n` at 2'b00 while the strobe is low. A byte read returns the byte selected by `req_addr[0]` (0 = bits 7:0) in `rsp_rdata[7:0]`, with all other bits zero.
- R6: In each access, chip select is low for max(setup,1)+hold cycles before the strobe falls, and the strobe stays low for max(data,1) cycles. The defaults are setup 3, hold 0, data 6 and turnaround 1.
- R7: Between the two accesses of a word, chip select stays high for exactly the turnaround count of cycles.
- R8: A write while `cfg_wr_en` is low produces no write strobe, leaves memory unchanged and completes with `rsp_err` high. Reads still work normally in that case.
- R9: A request while `cfg_bank_en` is low produces no chip-select activity and completes with `rsp_err` high.
- R10: `req_ready` is high only when the bridge is idle with chip select high. Each accepted request gets exactly one single-cycle `rsp_valid` pulse.
- R11: During a write strobe, `mem_oe_n` stays high and the bridge drives the write data on `mem_dq`. `mem_oe_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bank_en | input | 1 | Permits any memory access |
| cfg_wr_en | input | 1 | Permits write accesses |
| cfg_setup | input | 4 | Address-setup cycles (0 acts as 1) |
| cfg_hold | input | 4 | Address-hold cycles |
| cfg_data | input | 8 | Data-phase cycles (0 acts as 1) |
| cfg_turn | input | 4 | Turnaround cycles between accesses |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and able to accept |
| req_addr | input | 19 | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write data (byte in 7:0, halfword in 15:0) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, zero-extended |
| mem_addr | output | 18 | Halfword address to memory |
| mem_dq | inout | 16 | Bidirectional memory data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Byte-lane enables, active low (bit 0 = low byte) |

## Verification
The assertions take for granted that all `cfg_*` inputs stay constant from the acceptance of a request until the bridge is idle again. The assertion on write enable and the timing relations both depend on this. The bench changes configuration only while `req_ready` is high and no request is pending. The assertions also assume that the memory drives `mem_dq` only while output enable is low. The bench's memory model obeys that rule, so no bus contention arises.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HOLD,
        ST_DATA,
        ST_RESP,
        ST_TURN
    } bridge_state_t;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    localparam int MEM_DW = 16;
    localparam int REQ_DW = 32;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_pack.sv
module sram_lane_pack
    import sram_bridge_pkg::*;
(
    input  logic              is_byte,
    input  logic              is_word,
    input  logic              is_write,
    input  logic              byte_off,
    input  logic              beat,
    input  logic [REQ_DW-1:0] wdata,
    output logic [1:0]        lane_n,
    output logic [MEM_DW-1:0] wd
);
    always_comb begin
        lane_n = 2'b00;
        if (is_write && is_byte) begin
            lane_n = byte_off ? 2'b01 : 2'b10;
        end
    end

    always_comb begin
        if (is_byte) begin
            wd = {wdata[7:0], wdata[7:0]};
        end else if (is_word && beat) begin
            wd = wdata[31:16];
        end else begin
            wd = wdata[15:0];
        end
    end
endmodule

// File: rtl/sram_read_merge.sv
module sram_read_merge
    import sram_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              beat,
    input  logic [MEM_DW-1:0] dq_in,
    input  logic              is_byte,
    input  logic              is_word,
    input  logic              byte_off,
    input  logic              suppress,
    output logic [REQ_DW-1:0] rdata
);
    logic [MEM_DW-1:0] lo_q;
    logic [MEM_DW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (capture) begin
            if (beat) begin
                hi_q <= dq_in;
            end else begin
                lo_q <= dq_in;
            end
        end
    end

    always_comb begin
        if (suppress) begin
            rdata = '0;
        end else if (is_byte) begin
            rdata = {24'd0, (byte_off ? lo_q[15:8] : lo_q[7:0])};
        end else if (is_word) begin
            rdata = {hi_q, lo_q};
        end else begin
            rdata = {16'd0, lo_q};
        end
    end
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int HW_AW   = 18,
    parameter int SHORT_W = 4,
    parameter int LONG_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_bank_en,
    input  logic               cfg_wr_en,
    input  logic [SHORT_W-1:0] cfg_setup,
    input  logic [SHORT_W-1:0] cfg_hold,
    input  logic [LONG_W-1:0]  cfg_data,
    input  logic [SHORT_W-1:0] cfg_turn,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [HW_AW:0]     req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_write,
    input  logic [REQ_DW-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [REQ_DW-1:0]  rsp_rdata,
    output logic [HW_AW-1:0]   mem_addr,
    inout  wire  [MEM_DW-1:0]  mem_dq,
    output logic               mem_cs_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [1:0]         mem_lane_n
);
    localparam int BYTE_AW = HW_AW + 1;
    localparam int CNT_W   = (LONG_W > SHORT_W) ? LONG_W : SHORT_W;

    bridge_state_t state_q, state_d;

    logic [BYTE_AW-1:0] addr_q;
    logic [1:0]         size_q;
    logic               wr_q;
    logic [REQ_DW-1:0]  wdata_q;
    logic               beat_q;
    logic               err_q;
    logic               resp_sent_q;

    logic               accept;
    logic               reject;
    logic               is_byte;
    logic               is_word;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_expired;
    logic [CNT_W-1:0]   setup_len;
    logic [CNT_W-1:0]   hold_len;
    logic [CNT_W-1:0]   data_len;
    logic [CNT_W-1:0]   turn_len;
    logic               in_access;
    logic               drive_dq;
    logic [1:0]         lane_calc;
    logic [MEM_DW-1:0]  wd16;
    logic               rd_capture;

    assign is_byte = (size_q == SZ_BYTE);
    assign is_word = size_q[1];
    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign reject  = !cfg_bank_en || (req_write && !cfg_wr_en);

    // phase lengths; setup and data never shorter than one cycle
    assign setup_len = (cfg_setup == '0) ? CNT_W'(1) : CNT_W'(cfg_setup);
    assign hold_len  = CNT_W'(cfg_hold);
    assign data_len  = (cfg_data == '0) ? CNT_W'(1) : CNT_W'(cfg_data);
    assign turn_len  = CNT_W'(cfg_turn);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and progress flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            size_q      <= SZ_HALF;
            wr_q        <= 1'b0;
            wdata_q     <= '0;
            beat_q      <= 1'b0;
            err_q       <= 1'b0;
            resp_sent_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q      <= req_addr;
                size_q      <= req_size;
                wr_q        <= req_write;
                wdata_q     <= req_wdata;
                beat_q      <= 1'b0;
                err_q       <= reject;
                resp_sent_q <= 1'b0;
            end
            if (state_q == ST_DATA && tmr_expired && is_word && !beat_q) begin
                beat_q <= 1'b1;
            end
            if (state_q == ST_RESP) begin
                resp_sent_q <= 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = reject ? ST_RESP : ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d = (hold_len != '0) ? ST_HOLD : ST_DATA;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (tmr_expired) begin
                    if (is_word && !beat_q) begin
                        state_d = (turn_len != '0) ? ST_TURN : ST_SETUP;
                    end else begin
                        state_d = ST_RESP;
                    end
                end
            end
            ST_RESP: begin
                state_d = (!err_q && turn_len != '0) ? ST_TURN : ST_IDLE;
            end
            ST_TURN: begin
                if (tmr_expired) begin
                    state_d = resp_sent_q ? ST_IDLE : ST_SETUP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // phase timer reload on every state change
    always_comb begin
        tmr_val = '0;
        unique case (state_d)
            ST_SETUP: tmr_val = setup_len - 1'b1;
            ST_HOLD:  tmr_val = hold_len - 1'b1;
            ST_DATA:  tmr_val = data_len - 1'b1;
            ST_TURN:  tmr_val = turn_len - 1'b1;
            default:  tmr_val = '0;
        endcase
    end

    assign tmr_load = (state_d != state_q);

    sram_phase_timer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_lane_pack u_pack (
        .is_byte  (is_byte),
        .is_word  (is_word),
        .is_write (wr_q),
        .byte_off (addr_q[0]),
        .beat     (beat_q),
        .wdata    (wdata_q),
        .lane_n   (lane_calc),
        .wd       (wd16)
    );

    assign rd_capture = (state_q == ST_DATA) && tmr_expired && !wr_q;

    sram_read_merge u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rd_capture),
        .beat     (beat_q),
        .dq_in    (mem_dq),
        .is_byte  (is_byte),
        .is_word  (is_word),
        .byte_off (addr_q[0]),
        .suppress (err_q || wr_q),
        .rdata    (rsp_rdata)
    );

    // output decode from state
    always_comb begin
        in_access = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        drive_dq  = 1'b0;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_SETUP: in_access = 1'b1;
            ST_HOLD:  in_access = 1'b1;
            ST_DATA: begin
                in_access = 1'b1;
                mem_oe_n  = wr_q;
                mem_we_n  = !wr_q;
                drive_dq  = wr_q;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_err   = err_q;
            end
            ST_TURN:  in_access = 1'b0;
            default:  in_access = 1'b0;
        endcase
    end

    assign mem_cs_n   = !in_access;
    assign mem_lane_n = in_access ? lane_calc : 2'b11;
    assign mem_addr   = is_word ? {addr_q[BYTE_AW-1:2], beat_q} : addr_q[BYTE_AW-1:1];
    assign mem_dq     = drive_dq ? wd16 : {MEM_DW{1'bz}};

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_bank_en,
    input logic       cfg_wr_en,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       mem_cs_n,
    input logic       mem_oe_n,
    input logic       mem_we_n,
    input logic [1:0] mem_lane_n
);
    AST_LANES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> mem_lane_n == 2'b11); // R1
    AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_lane_n == 2'b00); // R5
    AST_BYTE_LANE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_lane_n != 2'b11); // R4
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n); // R6
    AST_SETUP_LEADS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> $past(!mem_cs_n)); // R6
    AST_SETUP_LEADS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n)); // R6
    AST_WE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (cfg_wr_en && cfg_bank_en)); // R8
    AST_CS_NEEDS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> cfg_bank_en); // R9
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !rsp_valid)); // R10
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R11
endmodule

bind sram_bridge sram_bridge_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_bank_en (cfg_bank_en),
    .cfg_wr_en   (cfg_wr_en),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_lane_n  (mem_lane_n)
);

// File: tb/sim_sram_bridge.sv
`timescale 1ns/100ps
module sim_sram_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bank_en = 1'b1;
    logic        cfg_wr_en = 1'b1;
    logic [3:0]  cfg_setup = 4'd3;
    logic [3:0]  cfg_hold = 4'd0;
    logic [7:0]  cfg_data = 8'd6;
    logic [3:0]  cfg_turn = 4'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [18:0] req_addr = '0;
    logic [1:0]  req_size = 2'b01;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic [17:0] mem_addr;
    wire  [15:0] mem_dq;
    logic        mem_cs_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [1:0]  mem_lane_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sram_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cfg_bank_en(cfg_bank_en), .cfg_wr_en(cfg_wr_en),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_data(cfg_data), .cfg_turn(cfg_turn),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n)
    );

    // memory model
    logic [15:0] mem [0:255];
    logic        pl_en = 1'b0;
    logic [7:0]  pl_addr = '0;
    logic [15:0] pl_data = '0;

    assign mem_dq = (!mem_cs_n && !mem_oe_n) ? mem[mem_addr[7:0]] : 16'hzzzz;

    always @(posedge clk) begin
        if (pl_en) begin
            mem[pl_addr] <= pl_data;
        end else if (!mem_cs_n && !mem_we_n) begin
            if (!mem_lane_n[0]) mem[mem_addr[7:0]][7:0]  <= mem_dq[7:0];
            if (!mem_lane_n[1]) mem[mem_addr[7:0]][15:8] <= mem_dq[15:8];
        end
    end

    // bus monitor
    int          n_acc, pre0, len0, gap, cs_cnt, we_cnt, rsp_cnt, busy_ready;
    logic [17:0] acc_addr [0:1];
    logic [1:0]  acc_lane [0:1];
    logic [15:0] acc_dq   [0:1];
    logic        prev_strobe = 1'b0;

    task automatic clear_mon();
        n_acc = 0; pre0 = 0; len0 = 0; gap = 0;
        cs_cnt = 0; we_cnt = 0; rsp_cnt = 0; busy_ready = 0;
    endtask

    always @(negedge clk) begin
        logic strobe;
        strobe = !mem_oe_n || !mem_we_n;
        if (!mem_cs_n) cs_cnt++;
        if (!mem_we_n) we_cnt++;
        if (rsp_valid) rsp_cnt++;
        if (req_ready && !mem_cs_n) busy_ready++;
        if (!mem_cs_n && !strobe && n_acc == 0) pre0++;
        if (mem_cs_n && n_acc == 1) gap++;
        if (strobe) begin
            if (!prev_strobe && n_acc < 2) begin
                acc_addr[n_acc] = mem_addr;
                acc_lane[n_acc] = mem_lane_n;
                acc_dq[n_acc]   = mem_dq;
                n_acc++;
            end
            if (n_acc == 1) len0++;
        end
        prev_strobe = strobe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] a, input logic [15:0] d);
        pl_en = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic do_req(input logic [18:0] a, input logic [1:0] sz, input logic w,
                          input logic [31:0] wd, output logic [31:0] rd, output logic e);
        clear_mon();
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = w; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_rdata;
        e  = rsp_err;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 cs_n", 32'(mem_cs_n), 32'd1);
        chk("R1 oe_n/we_n", {30'd0, mem_oe_n, mem_we_n}, 32'd3);
        chk("R1 lanes", 32'(mem_lane_n), 32'd3);
        chk("R1 ready/rsp", {30'd0, req_ready, rsp_valid}, 32'd2);
    endtask

    task automatic t_half_read();
        logic [31:0] rd; logic e;
        preload(8'd5, 16'hBEEF);
        do_req(19'h0A, 2'b01, 1'b0, 32'd0, rd, e);
        chk("R2 half read data", rd, 32'h0000BEEF);
        chk("R2 half addr", 32'(acc_addr[0]), 32'd5);
        chk("R2 one access", 32'(n_acc), 32'd1);
        chk("R5 read lanes", 32'(acc_lane[0]), 32'd0);
        chk("R6 default pre-strobe", 32'(pre0), 32'd3);
        chk("R6 default strobe", 32'(len0), 32'd6);
        chk("R10 one response", 32'(rsp_cnt), 32'd1);
        chk("R10 ready while busy", 32'(busy_ready), 32'd0);
    endtask

    task automatic t_word_read(input int exp_pre, input int exp_len, input int exp_gap);
        logic [31:0] rd; logic e;
        preload(8'd8, 16'h1111);
        preload(8'd9, 16'h2222);
        do_req(19'h10, 2'b10, 1'b0, 32'd0, rd, e);
        chk("R3 word read data", rd, 32'h22221111);
        chk("R3 two accesses", 32'(n_acc), 32'd2);
        chk("R3 first addr", 32'(acc_addr[0]), 32'd8);
        chk("R3 second addr", 32'(acc_addr[1]), 32'd9);
        chk("R3 single response", 32'(rsp_cnt), 32'd1);
        chk("R6 pre-strobe", 32'(pre0), 32'(exp_pre));
        chk("R6 strobe len", 32'(len0), 32'(exp_len));
        chk("R7 turnaround gap", 32'(gap), 32'(exp_gap));
    endtask

    task automatic t_byte_read();
        logic [31:0] rd; logic e;
        do_req(19'h0B, 2'b00, 1'b0, 32'd0, rd, e);
        chk("R5 byte read odd", rd, 32'h000000BE);
        chk("R5 byte read lanes", 32'(acc_lane[0]), 32'd0);
        do_req(19'h0A, 2'b00, 1'b0, 32'd0, rd, e);
        chk("R5 byte read even", rd, 32'h000000EF);
    endtask

    task automatic t_byte_write();
        logic [31:0] rd; logic e;
        preload(8'd16, 16'hAAAA);
        do_req(19'h20, 2'b00, 1'b1, 32'h0000005C, rd, e);
        chk("R4 even lane", 32'(acc_lane[0]), 32'd2);
        chk("R4 even result", 32'(mem[16]), 32'h0000AA5C);
        do_req(19'h21, 2'b00, 1'b1, 32'h00000033, rd, e);
        chk("R4 odd lane", 32'(acc_lane[0]), 32'd1);
        chk("R4 odd result", 32'(mem[16]), 32'h0000335C);
        chk("R4 no error", 32'(e), 32'd0);
    endtask

    task automatic t_half_write();
        logic [31:0] rd; logic e;
        do_req(19'h30, 2'b01, 1'b1, 32'h00001234, rd, e);
        chk("R11 driven dq", 32'(acc_dq[0]), 32'h00001234);
        chk("R11 stored", 32'(mem[24]), 32'h00001234);
        chk("R11 we cycles", 32'(we_cnt), 32'd6);
    endtask

    task automatic t_word_write();
        logic [31:0] rd; logic e;
        do_req(19'h40, 2'b10, 1'b1, 32'hCAFEBABE, rd, e);
        chk("R3 word write low", 32'(mem[32]), 32'h0000BABE);
        chk("R3 word write high", 32'(mem[33]), 32'h0000CAFE);
        chk("R3 write accesses", 32'(n_acc), 32'd2);
    endtask

    task automatic t_wr_disabled();
        logic [31:0] rd; logic e;
        cfg_wr_en = 1'b0;
        do_req(19'h30, 2'b01, 1'b1, 32'h00009999, rd, e);
        chk("R8 error flag", 32'(e), 32'd1);
        chk("R8 no strobe", 32'(we_cnt), 32'd0);
        chk("R8 memory kept", 32'(mem[24]), 32'h00001234);
        do_req(19'h30, 2'b01, 1'b0, 32'd0, rd, e);
        chk("R8 read still works", rd, 32'h00001234);
        chk("R8 read no error", 32'(e), 32'd0);
        cfg_wr_en = 1'b1;
    endtask

    task automatic t_bank_disabled();
        logic [31:0] rd; logic e;
        cfg_bank_en = 1'b0;
        do_req(19'h0A, 2'b01, 1'b0, 32'd0, rd, e);
        chk("R9 read error", 32'(e), 32'd1);
        chk("R9 read no cs", 32'(cs_cnt), 32'd0);
        do_req(19'h30, 2'b01, 1'b1, 32'h00005555, rd, e);
        chk("R9 write error", 32'(e), 32'd1);
        chk("R9 write no cs", 32'(cs_cnt), 32'd0);
        chk("R9 memory kept", 32'(mem[24]), 32'h00001234);
        cfg_bank_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_half_read();
        t_word_read(3, 6, 1);
        t_byte_read();
        t_byte_write();
        t_half_write();
        t_word_write();
        cfg_setup = 4'd0; cfg_hold = 4'd2; cfg_data = 8'd1; cfg_turn = 4'd3;
        t_word_read(3, 1, 3);
        cfg_setup = 4'd2; cfg_hold = 4'd0; cfg_data = 8'd2; cfg_turn = 4'd0;
        t_word_read(2, 2, 0);
        cfg_setup = 4'd3; cfg_data = 8'd6; cfg_turn = 4'd1;
        t_wr_disabled();
        t_bank_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule